// File: doc/BRIEF.md
# Range-Folding Digital Phase Meter

This block measures the signed phase offset between two square waves of equal frequency and reports it in whole degrees over the full circle, from -180 to +180. Positive values mean that the second input (B) lags the first (A). The measurement is taken in clock cycles. The period is the spacing between rising edges of A. The delay is the time from a rising edge of A to the selected edge of B.

Edge-counting phase detectors lose accuracy when the two edges nearly collide, which happens around 180 degrees. To avoid that region, a quadrature test first decides whether the offset magnitude is below 90 degrees. If it is not, the B channel is effectively inverted by an XOR stage, so the detector counts to the falling edge of B instead of the rising edge. The core therefore only ever measures an offset within plus or minus 90 degrees. A correction stage then adds or removes half a turn, using the quadrature flag, to rebuild the true reading.

Each finished A period produces one reading together with a one-cycle strobe. When A stops toggling, a timeout freezes the output and re-arms the measurement chain.

Top module: `phase_fold_meter`

## Requirements
- R1: Both inputs are resynchronized through two flip-flops. A reading closed by a rising edge of A appears on `phase_vld` exactly 3 clock cycles after that rising edge on the `sig_a` pin.
- R2: After reset, and after every timeout, no strobe is given until the 4th rising edge of A. The first strobe is tied to that 4th edge.
- R3: The quadrature flag is the level of B sampled floor(Pprev/4) cycles after a rising edge of A, where Pprev is the period measured most recently. A value of 1 means the offset lies in (-90, +90]. This flag is applied over the next A period, and `quad_ok` reports the flag that was applied to the reading shown.
- R4: With flag 1 the core counts d, the number of cycles from the A rising edge to the first rising edge of B. With flag 0 it counts to the first falling edge of B, which is the XOR inversion. The signed count is s = d when 2d <= P, and s = d - P otherwise, where P is the period that just closed.
- R5: The folded reading is floor(|s|*360/P), negated when s is negative.
- R6: With flag 1 the output equals the folded reading. With flag 0 the output is the folded reading + 180 when s is negative, and the folded reading - 180 otherwise. The output always lies in [-180, +180].
- R7: In steady operation `phase_vld` pulses for one cycle per A period. `phase_deg` holds its value between pulses.
- R8: If TIMEOUT cycles pass with no rising edge of A, no strobe is given and `phase_deg` stays frozen. Restart then follows R2.
- R9: While reset is held, `phase_vld` is 0, `phase_deg` is 0 and `quad_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_a | input | 1 | Reference square wave |
| sig_b | input | 1 | Measured square wave |
| phase_deg | output | 9 | Signed phase of B behind A, in degrees |
| phase_vld | output | 1 | One-cycle strobe for a new reading |
| quad_ok | output | 1 | Flag used for the reading: 1 when the magnitude is below 90 degrees |

## Verification
The bench drives both waves on falling clock edges, with integer periods and delays. A reading is therefore due 3 cycles after the `sig_a` rise that closes it: two synchronizer flops and the output register. The bench records the cycle of the 4th A edge of each burst and requires the first strobe exactly 3 cycles later. It also requires exactly three fewer strobes than A edges over the burst. Values are sampled at falling edges, half a cycle after the register updates. Idle gaps that are longer than TIMEOUT are checked for silence and for a frozen output before the next burst begins.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    localparam int DEG_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_PER   = 2'd2,
        ST_RUN   = 2'd3
    } stage_e;
endpackage

// File: rtl/pfm_sync.sv
module pfm_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prv
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_s;

    sync_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl = r_q.s2;
    assign prv = r_q.s3;

    // R1: a detected rising edge can never repeat on the next cycle
    for (genvar i = 0; i < W; i++) begin : g_chk
        p_single_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] && !prv[i]) |=> !(lvl[i] && !prv[i]));
    end
endmodule

// File: rtl/pfm_core.sv
module pfm_core import pfm_pkg::*; #(
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_lvl,
    input  logic             a_prv,
    input  logic             b_lvl,
    input  logic             b_prv,
    output logic             done_o,
    output logic [CNT_W-1:0] dly_o,
    output logic [CNT_W-1:0] per_o,
    output logic             quad_o
);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        stage_e           st;
        logic [CNT_W-1:0] t;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] dly;
        logic             seen;
        logic             q;
        logic             qp;
    } core_s;

    core_s r_q, r_d;

    logic             a_rise;
    logic             q_eff;
    logic             bf_now;
    logic             bf_old;
    logic             bf_rise;
    logic             measuring;
    logic [CNT_W-1:0] elapsed;
    logic             done;

    always_comb begin
        a_rise    = a_lvl & ~a_prv;
        measuring = (r_q.st == ST_PER) || (r_q.st == ST_RUN);
        // the flag about to be applied governs an edge that coincides with A
        q_eff     = (a_rise && measuring) ? r_q.qp : r_q.q;
        bf_now    = b_lvl ^ ~q_eff;
        bf_old    = b_prv ^ ~q_eff;
        bf_rise   = bf_now & ~bf_old;
        elapsed   = r_q.t + 1'b1;

        r_d  = r_q;
        done = 1'b0;
        if (a_rise) begin
            r_d.t    = '0;
            r_d.seen = bf_rise;
            r_d.dly  = '0;
            unique case (r_q.st)
                ST_IDLE:  r_d.st = ST_ARMED;
                ST_ARMED: begin
                    r_d.st  = ST_PER;
                    r_d.per = elapsed;
                end
                ST_PER: begin
                    r_d.st  = ST_RUN;
                    r_d.per = elapsed;
                    r_d.q   = r_q.qp;
                end
                default: begin
                    r_d.per = elapsed;
                    r_d.q   = r_q.qp;
                    done    = r_q.seen;
                end
            endcase
        end else begin
            if (r_q.t == TO_LAST) r_d.st = ST_IDLE;
            else                  r_d.t  = elapsed;
            if (bf_rise && !r_q.seen) begin
                r_d.seen = 1'b1;
                r_d.dly  = elapsed;
            end
            if (measuring && (elapsed == (r_q.per >> 2))) r_d.qp = b_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.q    <= 1'b1;
            r_q.qp   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = done;
    assign dly_o  = r_q.dly;
    assign per_o  = elapsed;
    assign quad_o = r_q.q;

    // R4: the latched delay always falls inside the period it closes
    p_dly_in_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dly_o < per_o));

    // R8: an expired window drops the chain back to idle
    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.t == TO_LAST && !a_rise) |=> (r_q.st == ST_IDLE));

    // R3: the applied flag only moves on a reference edge
    p_flag_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rise |=> $stable(r_q.q));
endmodule

// File: rtl/pfm_fold_fix.sv
module pfm_fold_fix import pfm_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic                    [CNT_W-1:0] dly,
    input  logic                    [CNT_W-1:0] per,
    input  logic                                quad,
    output logic signed [DEG_W-1:0]             deg
);
    localparam int PW = CNT_W + 9;
    localparam logic signed [DEG_W-1:0] HALF = DEG_W'(180);

    logic                    neg;
    logic        [CNT_W-1:0] mag;
    logic        [PW-1:0]    prod;
    logic        [PW-1:0]    quo;
    logic signed [DEG_W-1:0] fold_u;
    logic signed [DEG_W-1:0] fold_s;

    always_comb begin
        neg    = {dly, 1'b0} > {1'b0, per};
        mag    = neg ? (per - dly) : dly;
        prod   = PW'(mag) * PW'(360);
        quo    = (per == '0) ? '0 : (prod / PW'(per));
        fold_u = $signed(DEG_W'(quo));
        fold_s = neg ? -fold_u : fold_u;
        if (quad)     deg = fold_s;
        else if (neg) deg = fold_s + HALF;
        else          deg = fold_s - HALF;
    end
endmodule

// File: rtl/phase_fold_meter.sv
module phase_fold_meter import pfm_pkg::*; #(
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sig_a,
    input  logic                    sig_b,
    output logic signed [DEG_W-1:0] phase_deg,
    output logic                    phase_vld,
    output logic                    quad_ok
);
    typedef struct packed {
        logic signed [DEG_W-1:0] phase;
        logic                    vld;
        logic                    quad;
    } out_s;

    out_s r_q, r_d;

    logic [1:0]              lvl;
    logic [1:0]              prv;
    logic                    done;
    logic [CNT_W-1:0]        dly;
    logic [CNT_W-1:0]        per;
    logic                    quad;
    logic signed [DEG_W-1:0] fix_deg;

    pfm_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sig_b, sig_a}),
        .lvl   (lvl),
        .prv   (prv)
    );

    pfm_core #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_lvl  (lvl[0]),
        .a_prv  (prv[0]),
        .b_lvl  (lvl[1]),
        .b_prv  (prv[1]),
        .done_o (done),
        .dly_o  (dly),
        .per_o  (per),
        .quad_o (quad)
    );

    pfm_fold_fix #(.CNT_W(CNT_W)) u_fix (
        .dly  (dly),
        .per  (per),
        .quad (quad),
        .deg  (fix_deg)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = done;
        if (done) begin
            r_d.phase = fix_deg;
            r_d.quad  = quad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase <= '0;
            r_q.vld   <= 1'b0;
            r_q.quad  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign phase_deg = r_q.phase;
    assign phase_vld = r_q.vld;
    assign quad_ok   = r_q.quad;

    // R6: every reading stays on the circle
    p_out_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |-> (phase_deg >= -180 && phase_deg <= 180));

    // R7: strobe is a single-cycle pulse
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |=> !phase_vld);

    // R7: reading holds while no strobe is raised
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vld |-> $stable(phase_deg));
endmodule

// File: tb/phase_fold_meter_test.sv
`timescale 1ns/1ps
module phase_fold_meter_test;
    localparam int CW = 16;
    localparam int TO = 600;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sig_a = 1'b0;
    logic              sig_b = 1'b0;
    logic signed [8:0] phase_deg;
    logic              phase_vld;
    logic              quad_ok;

    phase_fold_meter #(.CNT_W(CW), .TIMEOUT(TO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_a     (sig_a),
        .sig_b     (sig_b),
        .phase_deg (phase_deg),
        .phase_vld (phase_vld),
        .quad_ok   (quad_ok)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    int          exp_ph;
    bit          exp_q;
    bit          seg_on = 0;
    int          vld_cnt = 0;
    int unsigned first_vld_cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // expected reading from R3..R6
    function automatic void exp_reading(input int p, input int d0, output int ph, output bit q);
        int h, quarter, d, mag, f, sf;
        bit neg;
        h       = p / 2;
        quarter = p / 4;
        q       = ((quarter + p - d0) % p) < h;        // R3
        d       = q ? d0 : (d0 + h) % p;               // R4
        neg     = (2 * d) > p;
        mag     = neg ? p - d : d;
        f       = (mag * 360) / p;                      // R5
        sf      = neg ? -f : f;
        if (q)        ph = sf;                          // R6
        else if (neg) ph = sf + 180;
        else          ph = sf - 180;
    endfunction

    always @(negedge clk) begin
        if (rst_n && phase_vld) begin
            vld_cnt++;
            if (vld_cnt == 1) first_vld_cyc = cyc;
            if (seg_on) begin
                chk(int'(phase_deg) == exp_ph, "R4 R5 R6 phase reading", int'(phase_deg), exp_ph);
                chk(quad_ok == exp_q, "R3 quadrature flag", int'(quad_ok), int'(exp_q));
            end
        end
    end

    task automatic run_seg(input int p, input int d0, input int nper);
        int h;
        int rises;
        int unsigned c4;
        int hold_ph;
        h     = p / 2;
        rises = 0;
        c4    = 0;
        exp_reading(p, d0, exp_ph, exp_q);
        @(negedge clk);
        vld_cnt = 0;
        seg_on  = 1;
        for (int k = 0; k < nper * p; k++) begin
            if (k > 0) @(negedge clk);
            sig_a = (k % p) < h;
            sig_b = ((k + p - d0) % p) < h;
            if (k % p == 0) begin
                rises++;
                if (rises == 4) c4 = cyc;
            end
        end
        @(negedge clk);
        sig_a = 1'b0;
        sig_b = 1'b0;
        repeat (8) @(negedge clk);
        seg_on = 0;
        chk(vld_cnt == nper - 3, "R7 one pulse per period", vld_cnt, nper - 3);
        chk(first_vld_cyc == c4 + 3, "R1 R2 first reading at 4th edge plus 3",
            int'(first_vld_cyc), int'(c4 + 3));
        // R8: idle longer than the timeout
        hold_ph = int'(phase_deg);
        vld_cnt = 0;
        repeat (TO + 40) @(negedge clk);
        chk(vld_cnt == 0, "R8 no pulse while idle", vld_cnt, 0);
        chk(int'(phase_deg) == hold_ph, "R8 output frozen", int'(phase_deg), hold_ph);
    endtask

    initial begin
        int unsigned seed_v;
        int p, d0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(phase_vld == 1'b0, "R9 reset strobe", int'(phase_vld), 0);
        chk(int'(phase_deg) == 0, "R9 reset phase", int'(phase_deg), 0);
        chk(quad_ok == 1'b1, "R9 reset flag", int'(quad_ok), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // directed corners: every octant, the 90 and 180 boundaries
        for (int i = 0; i < 8; i++) run_seg(40, i * 5, 7);
        run_seg(37, 9, 6);
        run_seg(37, 28, 6);
        run_seg(8, 3, 6);

        seed_v = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) begin
            p  = 8 + int'($urandom % 193);
            d0 = int'($urandom % p);
            run_seg(p, d0, 6);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule